// File: doc/BRIEF.md
# Multiplexed Parallel Flash Bus Sequencer

This block connects an internal byte request port to an external 8-bit parallel flash that sits behind a narrow multiplexed bus. The high part of each 22-bit byte address reaches the flash through external 8-bit latches. The sequencer drives each address byte onto a shared address/data bus and loads it into its latch with a strobe code on two latch-enable lines. The lowest three address bits go out on dedicated lines for the whole transaction. After the address phase the sequencer runs the data phase with active-low chip-enable, output-enable and write-enable.

Each phase takes its length from a 32-bit timing word. The timed phases are the latch-to-access wait, the first access, the repeat access, the write-low width, the write-high width and the post-read bus release. In the base mode two latches reach a 512 KB window. In the extended mode a third 3-bit latch reaches 4 MB. The sequencer remembers what the external latches hold. A request whose upper address is already latched skips the address phase and uses the shorter repeat access time.

The request port takes one transaction at a time through a valid/ready handshake. A read returns its byte with a one-cycle valid pulse.

Top module: `pflash_seq`

## Requirements
- R1: While reset is held, and in the cycles after its release before any request, the outputs are fixed at these values: `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, `fl_le` is 0, `fl_ad_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the transaction has finished. The busy length is the sum of the phase lengths in R3, R6, R7, R8 and R9.
- R3: Each latch load takes three cycles with the byte driven on `fl_ad_out` and `fl_ad_oe` high: a setup cycle with `fl_le`=00, a strobe cycle and a hold cycle with `fl_le`=00. The latches are loaded in this order:
  - strobe code 01 carries address bits 10:3;
  - strobe code 10 carries address bits 18:11;
  - in the extended mode only, strobe code 11 carries address bits 21:19 on bus bits 2:0, with bus bits 7:3 at zero.
  `fl_a_lo` carries address bits 2:0 throughout the transaction.
- R4: With `ext_mode`=0 only the strobes 01 and 10 occur. Address bits 21:19 are ignored, so two requests that differ only there address the same flash byte and are treated as the same latched address.
- R5: The timing word is split into these fields:
  - release time: bits 2:0, extension bit 22;
  - first access: bits 6:3, extension bit 23;
  - repeat access: bits 10:7, extension bit 24;
  - latch-to-access: bits 13:11, extension bit 25;
  - write low: bits 16:14, extension bit 26;
  - write high: bits 19:17, extension bit 27.
  Each extension bit is the field's most significant bit. A field whose value is 0 gives a length of 1 cycle. Bits 21:20 and 31:28 have no effect.
- R6: After the last latch load the sequencer waits for the latch-to-access length. During the wait `fl_ce_n` is 1 and the bus is not driven.
- R7: A read holds `fl_ce_n` and `fl_oe_n` low for the access length with the bus undriven, and samples `fl_ad_in` in the last access cycle. In the following cycle it raises `rsp_valid` for exactly one cycle with that byte on `rsp_rdata`.
- R8: After a read, the sequencer holds `fl_ce_n` and `fl_oe_n` high with the bus undriven for the release length before `req_ready` returns.
- R9: A write drives `req_wdata` with `fl_ad_oe` high and `fl_ce_n` low in two steps: first with `fl_we_n` low for the write-low length, then with `fl_we_n` high for the write-high length. A write produces no `rsp_valid`.
- R10: A request whose mode and latched upper address both equal those of the last address load since reset skips the latch loads and the latch-to-access wait. The latched upper address is bits 21:3 in the extended mode and bits 18:3 in the base mode. A read that skips uses the repeat access length; any other read uses the first access length.
- R11: The bus is never driven while `fl_oe_n` is low, and `fl_oe_n` and `fl_we_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1: three latches (22-bit space), 0: two latches (19-bit space) |
| timing_cfg | input | 32 | Phase timing word |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 22 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 8 | Read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_le | output | 2 | Latch strobe code |
| fl_ad_out | output | 8 | Shared address/data bus, outbound value |
| fl_ad_oe | output | 1 | Drive enable for the shared bus |
| fl_ad_in | input | 8 | Shared address/data bus, inbound value |
| fl_a_lo | output | 3 | Dedicated low address lines |

## Verification
Three things happen on the same edge: the read data is sampled, the response register loads, and the release phase starts. With a release length of one, the response pulse falls in the only release cycle and idle returns in the very next cycle. The bench sets that case up with an all-zero timing word and then issues the next request in the first idle cycle. It judges the case by the cycle index of the response and by the busy length. The skip decision for that next request is made against the latched address that the previous request recorded. The bench provokes this with pairs of requests that share their upper address, including pairs that differ only in the ignored high bits in the base mode. Each pair is judged by its busy length and by the address seen in the flash model's latches.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  localparam int CNT_W   = 5;
  localparam int NFLD    = 6;
  localparam int EXT_LSB = 22;

  localparam int F_OFF   = 0;
  localparam int F_FIRST = 1;
  localparam int F_NEXT  = 2;
  localparam int F_L2W   = 3;
  localparam int F_WLO   = 4;
  localparam int F_WHI   = 5;

  typedef logic [CNT_W-1:0] len_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LSET, ST_LSTB, ST_LHLD, ST_WAITL,
    ST_RACC, ST_TURN, ST_WLO, ST_WHI
  } seq_state_e;

  function automatic int fld_lsb(input int i);
    case (i)
      0: return 0;
      1: return 3;
      2: return 7;
      3: return 11;
      4: return 14;
      default: return 17;
    endcase
  endfunction

  function automatic int fld_w(input int i);
    case (i)
      1, 2: return 4;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/pflash_timing_dec.sv
module pflash_timing_dec
  import pflash_pkg::*;
(
  input  logic [31:0]          cfg_i,
  output len_t [NFLD-1:0]      len_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^{cfg_i[21:20], cfg_i[31:28]};

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    localparam int LSB = fld_lsb(i);
    localparam int FW  = fld_w(i);
    logic [FW:0] raw;
    assign raw      = {cfg_i[EXT_LSB+i], cfg_i[LSB+FW-1:LSB]};
    assign len_o[i] = (raw == '0) ? CNT_W'(1) : CNT_W'(raw);
  end
endmodule

// File: rtl/pflash_phase_cnt.sv
module pflash_phase_cnt
  import pflash_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld_i,
  input  len_t val_i,
  output logic done_o
);
  len_t cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    cnt_en = ld_i || (cnt_q != '0);
    cnt_d  = ld_i ? (val_i - CNT_W'(1)) : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  assert_no_zero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |-> (val_i != '0));
endmodule

// File: rtl/pflash_addr_tag.sv
module pflash_addr_tag #(
  parameter int KEY_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             mode_i,
  output logic             hit_o
);
  logic             vld_q;
  logic             mode_q;
  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      mode_q <= 1'b0;
      key_q  <= '0;
    end else if (upd_i) begin
      vld_q  <= 1'b1;
      mode_q <= mode_i;
      key_q  <= key_i;
    end
  end

  assign hit_o = vld_q && (mode_q == mode_i) && (key_q == key_i);
endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
  import pflash_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 8,
  parameter int LO_W    = 3,
  parameter int BASE_AW = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic [31:0]       timing_cfg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic [1:0]        fl_le,
  output logic [DATA_W-1:0] fl_ad_out,
  output logic              fl_ad_oe,
  input  logic [DATA_W-1:0] fl_ad_in,
  output logic [LO_W-1:0]   fl_a_lo
);
  localparam int KEY_W = ADDR_W - LO_W;
  localparam int HI_W  = ADDR_W - BASE_AW;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  len_t [NFLD-1:0] lens;
  pflash_timing_dec u_dec (.cfg_i(timing_cfg), .len_o(lens));

  logic cnt_ld, cnt_done;
  len_t cnt_val;
  pflash_phase_cnt u_cnt (
    .clk(clk), .rst_n(rst_i_n), .ld_i(cnt_ld), .val_i(cnt_val), .done_o(cnt_done)
  );

  logic [KEY_W-1:0] req_key;
  logic             tag_upd, tag_hit;
  assign req_key = ext_mode ? req_addr[ADDR_W-1:LO_W]
                            : {{HI_W{1'b0}}, req_addr[BASE_AW-1:LO_W]};
  pflash_addr_tag #(.KEY_W(KEY_W)) u_tag (
    .clk(clk), .rst_n(rst_i_n), .upd_i(tag_upd), .key_i(req_key),
    .mode_i(ext_mode), .hit_o(tag_hit)
  );

  seq_state_e        st_q, st_d;
  logic [1:0]        idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic              wr_q, mode_q, rsp_q, rsp_d;
  logic              cap_en, rd_en;
  logic [1:0]        last_idx;

  assign last_idx = mode_q ? 2'd2 : 2'd1;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    cap_en  = 1'b0;
    tag_upd = 1'b0;
    cnt_ld  = 1'b0;
    cnt_val = lens[F_OFF];
    rsp_d   = 1'b0;
    rd_en   = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        cap_en = 1'b1;
        if (tag_hit) begin
          cnt_ld = 1'b1;
          if (req_write) begin st_d = ST_WLO;  cnt_val = lens[F_WLO];  end
          else           begin st_d = ST_RACC; cnt_val = lens[F_NEXT]; end
        end else begin
          tag_upd = 1'b1;
          idx_d   = 2'd0;
          st_d    = ST_LSET;
        end
      end
      ST_LSET: st_d = ST_LSTB;
      ST_LSTB: st_d = ST_LHLD;
      ST_LHLD: begin
        if (idx_q == last_idx) begin
          st_d = ST_WAITL; cnt_ld = 1'b1; cnt_val = lens[F_L2W];
        end else begin
          idx_d = idx_q + 2'd1; st_d = ST_LSET;
        end
      end
      ST_WAITL: if (cnt_done) begin
        cnt_ld = 1'b1;
        if (wr_q) begin st_d = ST_WLO;  cnt_val = lens[F_WLO];   end
        else      begin st_d = ST_RACC; cnt_val = lens[F_FIRST]; end
      end
      ST_RACC: if (cnt_done) begin
        rd_en = 1'b1; rsp_d = 1'b1;
        st_d = ST_TURN; cnt_ld = 1'b1; cnt_val = lens[F_OFF];
      end
      ST_TURN: if (cnt_done) st_d = ST_IDLE;
      ST_WLO: if (cnt_done) begin
        st_d = ST_WHI; cnt_ld = 1'b1; cnt_val = lens[F_WHI];
      end
      ST_WHI: if (cnt_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q  <= ST_IDLE;
      idx_q <= 2'd0;
      rsp_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      rsp_q <= rsp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      wr_q   <= 1'b0;
      mode_q <= 1'b0;
    end else if (cap_en) begin
      addr_q <= req_addr;
      wdat_q <= req_wdata;
      wr_q   <= req_write;
      mode_q <= ext_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   rdat_q <= '0;
    else if (rd_en) rdat_q <= fl_ad_in;
  end

  logic              in_latch, in_write;
  logic [DATA_W-1:0] lat_byte;
  logic [1:0]        lat_code;

  always_comb begin
    case (idx_q)
      2'd0:    begin lat_byte = addr_q[LO_W +: DATA_W];        lat_code = 2'b01; end
      2'd1:    begin lat_byte = addr_q[LO_W+DATA_W +: DATA_W]; lat_code = 2'b10; end
      default: begin lat_byte = DATA_W'(addr_q[ADDR_W-1:BASE_AW]); lat_code = 2'b11; end
    endcase
  end

  assign in_latch  = (st_q == ST_LSET) || (st_q == ST_LSTB) || (st_q == ST_LHLD);
  assign in_write  = (st_q == ST_WLO) || (st_q == ST_WHI);
  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdat_q;
  assign fl_ce_n   = !((st_q == ST_RACC) || in_write);
  assign fl_oe_n   = (st_q != ST_RACC);
  assign fl_we_n   = (st_q != ST_WLO);
  assign fl_le     = (st_q == ST_LSTB) ? lat_code : 2'b00;
  assign fl_ad_oe  = in_latch || in_write;
  assign fl_ad_out = in_latch ? lat_byte : (in_write ? wdat_q : '0);
  assign fl_a_lo   = addr_q[LO_W-1:0];

  assert_no_drive_on_read_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !fl_oe_n |-> !fl_ad_oe);
  assert_oe_we_excl_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(!fl_oe_n && !fl_we_n));
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid |=> !rsp_valid);
  assert_rsp_after_access_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid |-> $past(!fl_oe_n));
  assert_strobe_off_chip_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fl_le != 2'b00) |-> (fl_ce_n && fl_ad_oe));
  assert_lo_stable_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_a_lo));
  assert_base_two_latches_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fl_le == 2'b11) |-> mode_q);
endmodule

// File: tb/pflash_seq_tb_top.sv
module pflash_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_mode;
  logic [31:0] timing_cfg;
  logic        req_valid, req_ready, req_write;
  logic [21:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        fl_ce_n, fl_oe_n, fl_we_n, fl_ad_oe;
  logic [1:0]  fl_le;
  logic [7:0]  fl_ad_out, fl_ad_in;
  logic [2:0]  fl_a_lo;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench-side model of the external latches and flash contents
  logic [7:0] xl0 = 8'h00, xl1 = 8'h00;
  logic [2:0] xl2 = 3'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pflash_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .timing_cfg(timing_cfg),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_le(fl_le), .fl_ad_out(fl_ad_out),
    .fl_ad_oe(fl_ad_oe), .fl_ad_in(fl_ad_in), .fl_a_lo(fl_a_lo)
  );

  function automatic logic [7:0] fmem(input logic [21:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ {2'b00, a[21:16]} ^ 8'hA5;
  endfunction

  function automatic int lenf(input logic [31:0] c, input int lsb, input int w, input int e);
    int v;
    v = int'((c >> lsb) & ((32'd1 << w) - 32'd1));
    if (c[e]) v = v + (1 << w);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [18:0] keyf(input logic [21:0] a, input bit m);
    return m ? a[21:3] : {3'b000, a[18:3]};
  endfunction

  function automatic logic [21:0] maskf(input logic [21:0] a, input bit m);
    return m ? a : {3'b000, a[18:0]};
  endfunction

  always @(negedge clk) begin
    if (fl_le == 2'b01)      xl0 <= fl_ad_out;
    else if (fl_le == 2'b10) xl1 <= fl_ad_out;
    else if (fl_le == 2'b11) xl2 <= fl_ad_out[2:0];
  end

  assign fl_ad_in = fl_oe_n ? 8'h00 :
                    fmem(ext_mode ? {xl2, xl1, xl0, fl_a_lo} : {3'b000, xl1, xl0, fl_a_lo});

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  bit          tag_vld = 0;
  bit          tag_mode = 0;
  logic [18:0] tag_key = '0;

  task automatic txn(input bit wr, input logic [21:0] a, input logic [7:0] d,
                     input logic [31:0] cfg, input bit m);
    int t_off, t_first, t_next, t_l2w, t_wlo, t_whi;
    int nl, tl, ta, busy, oe_n_cnt, we_cnt, ce_cnt, stb, rsp_n, rsp_at;
    int quiet, post, post_drv, exp_busy;
    bit hit, got;
    logic [7:0]  rcap, wcap;
    logic [21:0] seen;
    t_off   = lenf(cfg, 0, 3, 22);
    t_first = lenf(cfg, 3, 4, 23);
    t_next  = lenf(cfg, 7, 4, 24);
    t_l2w   = lenf(cfg, 11, 3, 25);
    t_wlo   = lenf(cfg, 14, 3, 26);
    t_whi   = lenf(cfg, 17, 3, 27);
    hit = tag_vld && (tag_mode == m) && (tag_key == keyf(a, m));
    if (!hit) begin tag_vld = 1; tag_mode = m; tag_key = keyf(a, m); end
    nl = hit ? 0 : (m ? 3 : 2);
    tl = hit ? 0 : t_l2w;
    ta = hit ? t_next : t_first;
    exp_busy = wr ? (3*nl + tl + t_wlo + t_whi) : (3*nl + tl + ta + t_off);

    timing_cfg = cfg; ext_mode = m;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0; oe_n_cnt = 0; we_cnt = 0; ce_cnt = 0; stb = 0; rsp_n = 0; rsp_at = 0;
    quiet = 0; post = 0; post_drv = 0; got = 0; rcap = 0; wcap = 0; seen = 0;
    while (!req_ready && busy < 400) begin
      busy++;
      if (!fl_oe_n) oe_n_cnt++;
      if (!fl_we_n) begin we_cnt++; if (we_cnt == 1) wcap = fl_ad_out; end
      if (!fl_ce_n) ce_cnt++;
      if (fl_le != 2'b00) stb++;
      if (fl_le == 2'b11)
        chk(fl_ad_out[7:3] == 5'd0, "R3 upper strobe byte zero-filled", fl_ad_out, fl_ad_out & 8'h07);
      if (!fl_ce_n && !got) begin got = 1; seen = {xl2, xl1, xl0, fl_a_lo}; end
      if (!got && fl_ce_n && !fl_ad_oe) quiet++;
      if (got && fl_ce_n) begin post++; if (fl_ad_oe) post_drv++; end
      if (rsp_valid) begin rsp_n++; rsp_at = busy; rcap = rsp_rdata; end
      @(negedge clk);
    end
    chk(busy == exp_busy, "R2 busy length", busy, exp_busy);
    chk(stb == nl, (m ? "R3 strobe count" : "R4 strobe count base mode"), stb, nl);
    chk(quiet == tl, (hit ? "R10 skip of latch wait" : "R6 latch-to-access wait"), quiet, tl);
    chk(maskf(seen, m) == maskf(a, m), "R3 latched address", int'(maskf(seen, m)), int'(maskf(a, m)));
    if (wr) begin
      chk(we_cnt == t_wlo, "R9 write low width", we_cnt, t_wlo);
      chk(ce_cnt == t_wlo + t_whi, "R9 write chip-enable width", ce_cnt, t_wlo + t_whi);
      chk(wcap == d, "R9 write data", wcap, d);
      chk(rsp_n == 0, "R9 no response on write", rsp_n, 0);
      chk(oe_n_cnt == 0, "R11 no output enable on write", oe_n_cnt, 0);
    end else begin
      chk(oe_n_cnt == ta, (hit ? "R10 repeat access length" : "R7 first access length"), oe_n_cnt, ta);
      chk(rsp_n == 1, "R7 single response", rsp_n, 1);
      chk(rsp_at == 3*nl + tl + ta + 1, "R7 response cycle", rsp_at, 3*nl + tl + ta + 1);
      chk(rcap == fmem(maskf(a, m)), "R7 read data", rcap, fmem(maskf(a, m)));
      chk(post == t_off && post_drv == 0, "R8 release phase", post, t_off);
      chk(we_cnt == 0, "R11 no write enable on read", we_cnt, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357));
    rst_n = 1'b0; ext_mode = 1'b1; timing_cfg = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    #(CLK_PERIOD * 2 + 1);
    chk({fl_ce_n, fl_oe_n, fl_we_n} == 3'b111, "R1 strobes high in reset", {fl_ce_n, fl_oe_n, fl_we_n}, 7);
    chk(fl_le == 2'b00 && !fl_ad_oe, "R1 latches and bus idle in reset", {fl_le, fl_ad_oe}, 0);
    chk(req_ready && !rsp_valid, "R1 ready and no response in reset", {req_ready, rsp_valid}, 2);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !rsp_valid && fl_ce_n && !fl_ad_oe, "R1 idle after release",
        {req_ready, rsp_valid, fl_ce_n, fl_ad_oe}, 4'b1010);

    // R5: zero fields mean one cycle; back-to-back single-cycle release
    txn(0, 22'h000000, 8'h00, 32'h0000_0000, 1);
    txn(0, 22'h000001, 8'h00, 32'h0000_0000, 1);
    // R5: extension bit as MSB (first access raw 0 + ext = 16), reserved bits set
    txn(0, 22'h2ABCD0, 8'h00, 32'hF030_0000 | (32'd1 << 23) | (32'd2 << 11), 1);
    // R5: all ones
    txn(1, 22'h155555, 8'h3C, 32'hFFFF_FFFF, 1);
    txn(0, 22'h155552, 8'h00, 32'hFFFF_FFFF, 1);
    // R4: base mode, bits 21:19 ignored -> second request reuses latches
    txn(0, 22'h3A5A5A, 8'h00, 32'h0001_2345, 0);
    txn(0, {3'b010, 16'h4B4B, 3'b110}, 8'h00, 32'h0001_2345, 0);
    // R10: mode change with same address forces a fresh load
    txn(0, {3'b010, 16'h4B4B, 3'b110}, 8'h00, 32'h0001_2345, 1);
    // R10: write after read at same upper address
    txn(1, {3'b010, 16'h4B4B, 3'b001}, 8'hC3, 32'h0005_4321, 1);

    for (int i = 0; i < 150; i++) begin
      logic [21:0] a;
      logic [31:0] cfg;
      bit m, wr;
      cfg = $urandom;
      m   = ($urandom % 4 != 0) ? 1'b1 : 1'b0;
      wr  = ($urandom % 3 == 0);
      a   = 22'($urandom);
      if ($urandom % 2 == 0) a = {tag_key, 3'($urandom)};
      txn(wr, a, 8'($urandom), cfg, m);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule